// File: doc/BRIEF.md
# Multi-Mode PWM and Capture Timer

This block is one timer subsystem built around a single 16-bit counter datapath that software reconfigures at run time. In its dual mode the datapath splits into two independent 8-bit PWM lanes, each with its own period and duty. In its wide mode the two halves cascade into one 16-bit PWM channel. In capture mode the datapath becomes a free-running 16-bit counter whose value is latched when a selected edge arrives on either of two capture pins. A fourth mode holds the counter stopped. An 8-bit prescaler sits in front of the counter and divides the clock by any value from 1 to 256.

Software drives the block through a small word-wide register port. Writes are single-cycle strobes. Reads are combinational, and a read strobe on a capture register acknowledges that capture. Period and duty writes go to staging registers, and a lane's live values change only when that lane wraps, so no pulse is ever cut short or stretched. Every write to the control register restarts the datapath cleanly. The block has no data stream, so it has no valid/ready handshake. All pins are plain control and status signals.

Top module: `pwmcap_timer`

## Requirements
- R1: After reset, both PWM outputs, both capture flags and the interrupt are low, and the status register (address 6) and both capture registers (addresses 4 and 5) read 0.
- R2: With prescale value p written to address 1, the counter advances once every p+1 clocks, for every p from 0 to 255.
- R3: Mode 0 (control bits [1:0] = 0) gives two 8-bit lanes. Lane 0 uses bits [7:0] of period (address 2) and duty (address 3) and drives pwm_out[0]. Lane 1 uses bits [15:8] and drives pwm_out[1]. A lane with period P counts 0..P-1 and its output is high while its count is below its duty.
- R4: Mode 1 is a single 16-bit lane that uses the full period and duty and drives pwm_out[0]. In this mode pwm_out[1] stays low.
- R5: A duty of 0 holds a lane's output low. A duty greater than or equal to the period holds it high. A period of 0 holds the count at 0.
- R6: A write to period or duty changes only the staging copy. A lane takes the staged values at the clock on which its count wraps to 0.
- R7: Mode 2 runs a free-running 16-bit count. Each capture pin passes through two flops. Its edge select uses 00 for none, 01 for rising, 10 for falling and 11 for both (control bits [3:2] for pin 0, [5:4] for pin 1). On a selected edge, the count held just after the second clock edge that samples the new pin level is latched.
- R8: A capture sets that pin's pending flag (status bit 0 or 1, also on cap_flag). The pending flag clears when the capture register is read with rd_en.
- R9: A capture that arrives while that pin's pending flag is still set also sets its overrun flag (status bit 2 or 3). Writing a 1 to that status bit clears the overrun flag.
- R10: Any write to the control register (address 0) zeroes the counter and prescaler, copies staged period and duty into the live registers, and clears all pending and overrun flags.
- R11: irq is high exactly when control bit 6 is set and at least one pending or overrun flag is set.
- R12: In modes 2 and 3 both PWM outputs are low. In mode 3 the counter is held at 0 and capture pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe, acknowledges capture registers |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| cap_in | input | 2 | Capture pins (asynchronous) |
| pwm_out | output | 2 | PWM outputs |
| cap_flag | output | 2 | Capture pending flags |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- The counter holds still between prescaler ticks.
- Idle modes keep the outputs low.
- A zero duty or a saturated duty pins the output.
- An overrun flag rises only over a pending capture.
- A control write leaves the counter and the flags cleared.

Only the bench's scenarios can show the arithmetic results: high-time over whole periods across swept prescale, period and duty values, the deferred take-up of a new duty, the exact latched count for each edge select, and the acknowledge and overrun sequences seen through the register port.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [1:0] {
    MD_DUAL = 2'd0,
    MD_WIDE = 2'd1,
    MD_CAPT = 2'd2,
    MD_HALT = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    EDG_NONE = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_sel_e;

  localparam int ADR_W = 3;
  localparam logic [ADR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADR_W-1:0] ADR_PRESC = 3'd1;
  localparam logic [ADR_W-1:0] ADR_PER   = 3'd2;
  localparam logic [ADR_W-1:0] ADR_DUT   = 3'd3;
  localparam logic [ADR_W-1:0] ADR_CAPA  = 3'd4;
  localparam logic [ADR_W-1:0] ADR_CAPB  = 3'd5;
  localparam logic [ADR_W-1:0] ADR_STAT  = 3'd6;
endpackage

// File: rtl/pwmcap_prescale.sv
module pwmcap_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] acc;

  // >= rather than == so a smaller divisor written mid-count cannot strand acc
  assign tick = (acc >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else if (tick)    acc <= '0;
    else              acc <= acc + 1'b1;
  end
endmodule

// File: rtl/pwmcap_capsync.sv
module pwmcap_capsync
  import pwmcap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  edge_sel_e sel,
  output logic      evt
);
  logic s1, s2, s3;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    case (sel)
      EDG_RISE: evt = rise;
      EDG_FALL: evt = fall;
      EDG_BOTH: evt = rise | fall;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwmcap_counter.sv
module pwmcap_counter
  import pwmcap_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                tick,
  input  tmr_mode_e           mode,
  input  logic [2*HALF_W-1:0] per,
  input  logic [2*HALF_W-1:0] dut,
  output logic [2*HALF_W-1:0] cnt,
  output logic                end_lo,
  output logic                end_hi,
  output logic [1:0]          pwm
);
  localparam int W = 2 * HALF_W;

  logic [HALF_W-1:0] lo, hi;
  logic [W-1:0]      cnt_n;
  logic              wrap_lo, wrap_hi, wrap_w;

  assign lo = cnt[HALF_W-1:0];
  assign hi = cnt[W-1:HALF_W];

  // Wrap when the next count would reach the period; period 0 wraps every tick
  assign wrap_lo = tick && (({1'b0, lo} + 1'b1) >= {1'b0, per[HALF_W-1:0]});
  assign wrap_hi = tick && (({1'b0, hi} + 1'b1) >= {1'b0, per[W-1:HALF_W]});
  assign wrap_w  = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, per});

  always_comb begin
    cnt_n  = cnt;
    end_lo = 1'b0;
    end_hi = 1'b0;
    pwm    = 2'b00;
    case (mode)
      MD_DUAL: begin
        cnt_n[HALF_W-1:0] = wrap_lo ? '0 : lo + HALF_W'(tick);
        cnt_n[W-1:HALF_W] = wrap_hi ? '0 : hi + HALF_W'(tick);
        end_lo = wrap_lo;
        end_hi = wrap_hi;
        pwm    = {hi < dut[W-1:HALF_W], lo < dut[HALF_W-1:0]};
      end
      MD_WIDE: begin
        cnt_n  = wrap_w ? '0 : cnt + W'(tick);
        end_lo = wrap_w;
        end_hi = wrap_w;
        pwm    = {1'b0, cnt < dut};
      end
      MD_CAPT: cnt_n = cnt + W'(tick);
      default: cnt_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt_n;
  end
endmodule

// File: rtl/pwmcap_timer.sv
module pwmcap_timer
  import pwmcap_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [2*HALF_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [2:0]          rd_addr,
  output logic [2*HALF_W-1:0] rd_data,
  input  logic [1:0]          cap_in,
  output logic [1:0]          pwm_out,
  output logic [1:0]          cap_flag,
  output logic                irq
);
  localparam int W    = 2 * HALF_W;
  localparam int NCAP = 2;

  tmr_mode_e        mode_q;
  edge_sel_e        esel_q [NCAP];
  logic             ie_q;
  logic [PRE_W-1:0] presc_q;
  logic [W-1:0]     per_stg, dut_stg, per_act, dut_act;
  logic [W-1:0]     cap_val [NCAP];
  logic             pend    [NCAP];
  logic             ovr     [NCAP];
  logic [NCAP-1:0]  evt;
  logic             restart, tick, end_lo, end_hi;
  logic [W-1:0]     cnt;

  assign restart = wr_en && (wr_addr == ADR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_DUAL;
      esel_q[0] <= EDG_NONE;
      esel_q[1] <= EDG_NONE;
      ie_q      <= 1'b0;
      presc_q   <= '0;
      per_stg   <= '0;
      dut_stg   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          mode_q    <= tmr_mode_e'(wr_data[1:0]);
          esel_q[0] <= edge_sel_e'(wr_data[3:2]);
          esel_q[1] <= edge_sel_e'(wr_data[5:4]);
          ie_q      <= wr_data[6];
        end
        ADR_PRESC: presc_q <= wr_data[PRE_W-1:0];
        ADR_PER:   per_stg <= wr_data;
        ADR_DUT:   dut_stg <= wr_data;
        default: ;
      endcase
    end
  end

  // Live period/duty: each half follows its own lane's wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act <= '0;
      dut_act <= '0;
    end else if (restart) begin
      per_act <= per_stg;
      dut_act <= dut_stg;
    end else begin
      if (end_lo) begin
        per_act[HALF_W-1:0] <= per_stg[HALF_W-1:0];
        dut_act[HALF_W-1:0] <= dut_stg[HALF_W-1:0];
      end
      if (end_hi) begin
        per_act[W-1:HALF_W] <= per_stg[W-1:HALF_W];
        dut_act[W-1:HALF_W] <= dut_stg[W-1:HALF_W];
      end
    end
  end

  pwmcap_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(presc_q), .tick(tick)
  );

  pwmcap_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .mode(mode_q),
    .per(per_act), .dut(dut_act), .cnt(cnt), .end_lo(end_lo), .end_hi(end_hi),
    .pwm(pwm_out)
  );

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    logic hit, ack, w1c;

    pwmcap_capsync u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[g]), .sel(esel_q[g]), .evt(evt[g])
    );

    assign hit = evt[g] && (mode_q == MD_CAPT);
    assign ack = rd_en && (rd_addr == 3'(ADR_CAPA + g));
    assign w1c = wr_en && (wr_addr == ADR_STAT) && wr_data[2+g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_val[g] <= '0;
        pend[g]    <= 1'b0;
        ovr[g]     <= 1'b0;
      end else if (restart) begin
        pend[g] <= 1'b0;
        ovr[g]  <= 1'b0;
      end else begin
        if (w1c) ovr[g] <= 1'b0;
        if (hit) begin
          cap_val[g] <= cnt;
          pend[g]    <= 1'b1;
          if (pend[g] && !ack) ovr[g] <= 1'b1;
        end else if (ack) begin
          pend[g] <= 1'b0;
        end
      end
    end
  end

  assign cap_flag = {pend[1], pend[0]};
  assign irq      = ie_q & (pend[0] | pend[1] | ovr[0] | ovr[1]);

  always_comb begin
    case (rd_addr)
      ADR_CTRL:  rd_data = W'({ie_q, esel_q[1], esel_q[0], mode_q});
      ADR_PRESC: rd_data = W'(presc_q);
      ADR_PER:   rd_data = per_stg;
      ADR_DUT:   rd_data = dut_stg;
      ADR_CAPA:  rd_data = cap_val[0];
      ADR_CAPB:  rd_data = cap_val[1];
      ADR_STAT:  rd_data = W'({ovr[1], ovr[0], pend[1], pend[0]});
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwmcap_checker.sv
module pwmcap_checker
  import pwmcap_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart,
  input logic                tick,
  input tmr_mode_e           mode,
  input logic [2*HALF_W-1:0] cnt,
  input logic [2*HALF_W-1:0] act_per,
  input logic [2*HALF_W-1:0] act_dut,
  input logic [1:0]          pwm,
  input logic                pend_a,
  input logic                ovr_a,
  input logic                irq
);
  // R2: the count moves only on a prescaler tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(cnt));

  // R12: capture and halt modes keep both outputs low
  a_r12_idle_modes_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CAPT || mode == MD_HALT) |-> (pwm == 2'b00));

  // R5: zero duty on lane 0 holds it low in dual mode
  a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_DUAL && act_dut[HALF_W-1:0] == '0) |-> !pwm[0]);

  // R5: saturated duty holds the wide lane high
  a_r5_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_WIDE && act_dut >= act_per) |-> pwm[0]);

  // R9: an overrun only appears over a pending capture
  a_r9_overrun_over_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_a) |-> $past(pend_a));

  // R10: a control write leaves count, flags and interrupt clear
  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !pend_a && !ovr_a && !irq));
endmodule

bind pwmcap_timer pwmcap_checker #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .mode(mode_q),
  .cnt(cnt), .act_per(per_act), .act_dut(dut_act), .pwm(pwm_out),
  .pend_a(pend[0]), .ovr_a(ovr[0]), .irq(irq)
);

// File: tb/sim_pwmcap_timer.sv
module sim_pwmcap_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cap_in = 2'b00;
  logic [1:0]  pwm_out;
  logic [1:0]  cap_flag;
  logic        irq;

  pwmcap_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in),
    .pwm_out(pwm_out), .cap_flag(cap_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive at a negedge; returns at the next negedge (cycle 0 after the write)
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic ack(input int a);
    rd_en = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic measure(input int len, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      h0 += int'(pwm_out[0]);
      h1 += int'(pwm_out[1]);
    end
  endtask

  function automatic int ctrl(input int m, input int ea, input int eb, input int ie);
    return m | (ea << 2) | (eb << 4) | (ie << 6);
  endfunction

  // High cycles over two periods, counted from a restart
  function automatic int exp_high(input int per, input int dut, input int p, input int len);
    if (per == 0) return (dut > 0) ? len : 0;
    return 2 * (p + 1) * ((dut < per) ? dut : per);
  endfunction

  initial begin
    int v, h0, h1, len;
    int plist [3] = '{0, 1, 3};
    int wper  [3] = '{256, 300, 513};
    int wdut  [8] = '{0, 1, 255, 256, 299, 300, 400, 600};

    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check("R1 pwm", int'(pwm_out), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 cap_flag", int'(cap_flag), 0);
    rd(6, v); check("R1 status", v, 0);
    rd(4, v); check("R1 capA", v, 0);
    rd(5, v); check("R1 capB", v, 0);

    // R3/R5/R2 dual-mode sweep: lane1 shares the period, duty 7-D
    foreach (plist[k]) begin
      wr(1, plist[k]);
      for (int per = 0; per <= 6; per++) begin
        for (int d = 0; d <= 7; d++) begin
          wr(2, per * 257);
          wr(3, ((7 - d) << 8) | d);
          wr(0, ctrl(0, 0, 0, 0));
          len = 2 * (plist[k] + 1) * ((per == 0) ? 1 : per);
          measure(len, h0, h1);
          check((d == 0 || d >= per) ? "R5 lane0" : "R3 lane0", h0,
                exp_high(per, d, plist[k], len));
          check((7 - d >= per) ? "R5 lane1" : "R3 lane1", h1,
                exp_high(per, 7 - d, plist[k], len));
        end
      end
    end

    // R2 maximum prescale: divide by 256
    wr(1, 255); wr(2, 16'h0202); wr(3, 16'h0201); wr(0, ctrl(0, 0, 0, 0));
    measure(1024, h0, h1);
    check("R2 prescale 256 lane0", h0, 512);
    check("R2 prescale 256 lane1", h1, 1024);

    // R3 lanes with different periods
    wr(1, 0); wr(2, 16'h0503); wr(3, 16'h0402); wr(0, ctrl(0, 0, 0, 0));
    measure(30, h0, h1);
    check("R3 lane0 period3", h0, 20);
    check("R3 lane1 period5", h1, 24);

    // R4/R5 wide mode sweep
    foreach (wper[a]) begin
      foreach (wdut[b]) begin
        wr(2, wper[a]); wr(3, wdut[b]); wr(0, ctrl(1, 0, 0, 0));
        measure(2 * wper[a], h0, h1);
        check((wdut[b] == 0 || wdut[b] >= wper[a]) ? "R5 wide" : "R4 wide", h0,
              exp_high(wper[a], wdut[b], 0, 2 * wper[a]));
        check("R4 pwm1 low", h1, 0);
      end
    end

    // R6 duty written during first period takes effect at the wrap
    wr(2, 10); wr(3, 3); wr(0, ctrl(0, 0, 0, 0));
    h0 = 0; v = 0;
    for (int i = 0; i < 20; i++) begin
      if (i > 0) @(negedge clk);
      wr_en = 1'b0;
      h0 += int'(pwm_out[0]);
      if (i == 9) v = h0;
      if (i == 1) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd7; end
    end
    check("R6 first period keeps old duty", v, 3);
    check("R6 two periods", h0, 10);

    // R12 halt mode: outputs low, captures ignored
    wr(0, ctrl(3, 1, 1, 1));
    measure(20, h0, h1);
    check("R12 halt pwm0", h0, 0);
    check("R12 halt pwm1", h1, 0);
    cap_in[0] = 1'b1; step(6);
    rd(6, v); check("R12 halt capture ignored", v, 0);
    check("R12 halt irq", int'(irq), 0);
    cap_in[0] = 1'b0; step(4);

    // R7/R8/R11 capture: A rising, B falling, interrupt on
    wr(0, ctrl(2, 1, 2, 1));
    step(4);
    cap_in[0] = 1'b1;
    step(6);
    rd(4, v); check("R7 capA rising value", v, 6);
    rd(6, v); check("R8 pendA set", v, 1);
    check("R8 cap_flag", int'(cap_flag), 1);
    check("R11 irq on pending", int'(irq), 1);
    check("R12 capture mode pwm low", int'(pwm_out), 0);
    cap_in[1] = 1'b1;
    step(6);
    rd(6, v); check("R7 B rise ignored under falling select", v, 1);
    cap_in[1] = 1'b0;
    step(6);
    rd(5, v); check("R7 capB falling value", v, 18);
    rd(6, v); check("R8 both pending", v, 3);
    ack(4);
    rd(6, v); check("R8 read clears pendA", v, 2);
    ack(5);
    rd(6, v); check("R8 read clears pendB", v, 0);
    check("R11 irq drops", int'(irq), 0);

    // R9 overrun and its write-one clear
    cap_in[0] = 1'b0; step(4);
    cap_in[0] = 1'b1; step(4);
    cap_in[0] = 1'b0; step(4);
    cap_in[0] = 1'b1; step(6);
    rd(6, v); check("R9 overrun set", v, 5);
    wr(6, 4);
    rd(6, v); check("R9 overrun cleared by W1C", v, 1);
    check("R11 irq held by pending", int'(irq), 1);

    // R10 control write clears flags
    wr(0, ctrl(2, 3, 0, 0));
    rd(6, v); check("R10 flags cleared", v, 0);
    check("R10 irq cleared", int'(irq), 0);

    // R7 both edges: falling edge at cycle 0 latches count 2
    cap_in[0] = 1'b0;
    step(6);
    rd(4, v); check("R7 both-edge falling value", v, 2);
    check("R11 irq masked", int'(irq), 0);
    ack(4);
    cap_in[0] = 1'b1; step(6);
    rd(6, v); check("R7 both-edge rising sets pending", v, 1);

    // R7 select none ignores edges
    wr(0, ctrl(2, 0, 0, 1));
    cap_in[0] = 1'b0; step(6);
    cap_in[0] = 1'b1; step(6);
    rd(6, v); check("R7 none select ignored", v, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule